// File: doc/BRIEF.md
# AHB to APB Bridge

The bridge sits on the AHB as one slave and fans out to a set of low-power APB peripherals. Every AHB beat that carries a real transfer becomes exactly one APB transfer. That transfer has two cycles: a setup cycle with the peripheral's select raised, then an access cycle with the enable strobe raised as well. The peripherals share the address, direction, write data and enable lines. Each peripheral has its own select line, driven from a slot field of the address. Each peripheral returns its own read data bus, and the bridge picks the selected one.

The AHB side stalls through its ready output. While `bus_rdy` is low, the master must hold its current address phase, and the bridge ignores every address-phase input. `bus_rdy` goes high again in the access cycle. In that cycle a read returns its data, and a new address phase can be sampled, so one transfer can follow another with no gap. A read stalls the bus for one cycle. A write stalls it for two, because the write data only arrives in the AHB data phase. The response is always OKAY.

Top module: `ahb2apb_bridge`

## Requirements
- R1: Reset `rst_n` is asynchronous and active low. While it is low, and in the first cycle after it, all of `per_sel` is 0, `per_stb` is 0, `bus_rdy` is 1 and `bus_resp` is 2'b00 (OKAY).
- R2: No APB transfer starts for a beat whose `bus_kind` is idle (2'b00) or busy (2'b01), or whose `bus_sel` is low. In the next cycle `per_sel` is all zero, `bus_rdy` stays 1 and `bus_resp` is OKAY.
- R3: A read is a beat with `bus_kind` nonsequential (2'b10) or sequential (2'b11) and `bus_wr` = 0, sampled at a rising edge. The next cycle is setup: one select high, `per_stb` 0, `bus_rdy` 0. The cycle after that is access: the select and `per_stb` both high, `bus_rdy` 1. If no new transfer was sampled, the bridge then returns to idle with no select.
- R4: A write (`bus_wr` = 1) first spends one data-phase cycle with no select and `bus_rdy` 0. The value on `bus_wdata` at the end of that cycle is captured and appears on `per_wdata` through setup and access. Setup and access then follow as in R3.
- R5: `per_stb` is high only in the cycle right after a setup cycle (select high, strobe low). It is never high in two cycles in a row.
- R6: `per_addr`, `per_wr`, `per_wdata` and `per_sel` do not change between setup and access. `per_addr` equals the sampled `bus_addr`, and `per_wr` equals the sampled `bus_wr`.
- R7: Peripheral i is selected when `bus_addr[SLOT_LSB+IDX_W-1:SLOT_LSB]` equals i. With the defaults this is bits 13:12, and bit i of `per_sel` maps to peripheral i. At most one select is high at any time.
- R8: In the access cycle of a read, `bus_rdata` equals `per_rdata[i*DW +: DW]` of the selected peripheral i, `bus_rdy` is 1 and `bus_resp` is OKAY.
- R9: A transfer sampled in an access cycle starts at once. A read goes to setup in the next cycle, and a write goes to its data-phase cycle in the next cycle, with no idle cycle in between.
- R10: A beat is sampled only while `bus_rdy_in` is 1. With `bus_rdy_in` low, a nonsequential beat starts nothing and the bridge stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all transfers are timed on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | AHB slave select for the bridge |
| bus_addr | input | AW | AHB address, address phase |
| bus_kind | input | 2 | AHB transfer type: 00 idle, 01 busy, 10 nonsequential, 11 sequential |
| bus_wr | input | 1 | AHB direction: 1 write, 0 read |
| bus_wdata | input | DW | AHB write data, data phase |
| bus_rdy_in | input | 1 | Bus-wide ready; a beat is sampled only when it is high |
| bus_rdy | output | 1 | Bridge ready; low stalls the master |
| bus_resp | output | 2 | Response, always OKAY (00) |
| bus_rdata | output | DW | Read data, valid in the access cycle of a read |
| per_sel | output | NP | One select per APB peripheral |
| per_stb | output | 1 | Enable strobe, high in the access cycle |
| per_addr | output | AW | Latched APB address |
| per_wr | output | 1 | Latched APB direction |
| per_wdata | output | DW | Latched APB write data |
| per_rdata | input | NP*DW | Read data of every peripheral, peripheral i in slice i |

## Verification
Two functions fall in the same cycle: the access cycle completes a transfer (read data on `bus_rdata`, ready high), and it also samples the next address phase. The bench drives a new beat during an access cycle. It checks the returned read data in that same cycle. In the next cycle it checks whether a read went straight to setup or a write went to its data-phase wait. It also checks that the second transfer carries its own select, address and write data, not the values of the first.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WDATA  = 2'd1,
    ST_SETUP  = 2'd2,
    ST_ACCESS = 2'd3
  } br_state_e;

  localparam logic [1:0] KIND_IDLE   = 2'b00;
  localparam logic [1:0] KIND_BUSY   = 2'b01;
  localparam logic [1:0] KIND_NONSEQ = 2'b10;
  localparam logic [1:0] KIND_SEQ    = 2'b11;

  localparam logic [1:0] RESP_OKAY   = 2'b00;

endpackage

// File: rtl/apb_slot_decode.sv
module apb_slot_decode #(
  parameter int NP    = 4,
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0] slot_idx,
  output logic [NP-1:0]    slot_hit
);

  // One comparator per peripheral slot.
  for (genvar g = 0; g < NP; g++) begin : g_slot
    assign slot_hit[g] = (slot_idx == IDX_W'(g));
  end

endmodule

// File: rtl/apb_read_mux.sv
module apb_read_mux #(
  parameter int NP = 4,
  parameter int DW = 32
) (
  input  logic            en,
  input  logic [NP-1:0]   sel,
  input  logic [NP*DW-1:0] rd_all,
  output logic [DW-1:0]   rd_out
);

  // AND-OR selection; the select is one-hot, so no priority is needed.
  always_comb begin
    rd_out = '0;
    if (en) begin
      for (int i = 0; i < NP; i++) begin
        if (sel[i]) rd_out = rd_out | rd_all[i*DW +: DW];
      end
    end
  end

endmodule

// File: rtl/ahb2apb_seq.sv
module ahb2apb_seq
  import bridge_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic [1:0]    bus_kind,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rdy_in,
  input  logic [NP-1:0] dec_hit,
  output logic [NP-1:0] per_sel,
  output logic          per_stb,
  output logic [AW-1:0] per_addr,
  output logic          per_wr,
  output logic [DW-1:0] per_wdata,
  output logic          bus_rdy,
  output logic          in_access
);

  br_state_e     st, st_nx;
  logic          is_xfer, can_take, start;
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic [NP-1:0] sel_q;
  logic [DW-1:0] wdata_q;

  assign is_xfer  = (bus_kind == KIND_NONSEQ) || (bus_kind == KIND_SEQ);
  assign can_take = (st == ST_IDLE) || (st == ST_ACCESS);
  assign start    = can_take && bus_sel && bus_rdy_in && is_xfer;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:   if (start) st_nx = bus_wr ? ST_WDATA : ST_SETUP;
      ST_WDATA:  st_nx = ST_SETUP;
      ST_SETUP:  st_nx = ST_ACCESS;
      ST_ACCESS: st_nx = start ? (bus_wr ? ST_WDATA : ST_SETUP) : ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      sel_q   <= '0;
      wdata_q <= '0;
    end else begin
      st <= st_nx;
      if (start) begin
        addr_q <= bus_addr;
        wr_q   <= bus_wr;
        sel_q  <= dec_hit;
      end
      if (st == ST_WDATA) wdata_q <= bus_wdata;
    end
  end

  assign in_access = (st == ST_ACCESS);
  assign per_sel   = ((st == ST_SETUP) || (st == ST_ACCESS)) ? sel_q : '0;
  assign per_stb   = in_access;
  assign per_addr  = addr_q;
  assign per_wr    = wr_q;
  assign per_wdata = wdata_q;
  assign bus_rdy   = can_take;

  // R3: the setup cycle stalls the master and is followed by access
  p_setup_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|per_sel && !per_stb) |-> !bus_rdy);
  p_setup_then_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|per_sel && !per_stb) |=> (per_stb && |per_sel));

  // R5: strobe only in the second cycle of a transfer
  p_stb_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
    per_stb |-> $past(|per_sel && !per_stb));

  // R6: address, control and data held from setup into access
  p_hold_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    per_stb |-> ($stable(per_addr) && $stable(per_wr) &&
                 $stable(per_wdata) && $stable(per_sel)));

  // R4: a write first waits one data-phase cycle with no select
  p_write_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && bus_wr) |=> (!bus_rdy && per_sel == '0));
  p_wdata_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WDATA) |=> (per_wdata == $past(bus_wdata)));

  // R2: idle and busy beats start nothing
  p_idle_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdy && bus_sel && !bus_kind[1]) |=> (per_sel == '0 && bus_rdy));

  // R10: nothing is sampled while the bus-wide ready is low
  p_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !bus_rdy_in) |=> (per_sel == '0 && bus_rdy));

endmodule

// File: rtl/ahb2apb_bridge.sv
module ahb2apb_bridge
  import bridge_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int NP       = 4,
  parameter int SLOT_LSB = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic [AW-1:0]    bus_addr,
  input  logic [1:0]       bus_kind,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_rdy_in,
  output logic             bus_rdy,
  output logic [1:0]       bus_resp,
  output logic [DW-1:0]    bus_rdata,
  output logic [NP-1:0]    per_sel,
  output logic             per_stb,
  output logic [AW-1:0]    per_addr,
  output logic             per_wr,
  output logic [DW-1:0]    per_wdata,
  input  logic [NP*DW-1:0] per_rdata
);

  localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1;

  logic [IDX_W-1:0] slot_idx;
  logic [NP-1:0]    dec_hit;
  logic             in_access;

  assign slot_idx = bus_addr[SLOT_LSB +: IDX_W];

  apb_slot_decode #(.NP(NP), .IDX_W(IDX_W)) u_dec (
    .slot_idx (slot_idx),
    .slot_hit (dec_hit)
  );

  ahb2apb_seq #(.AW(AW), .DW(DW), .NP(NP)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_kind   (bus_kind),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdy_in (bus_rdy_in),
    .dec_hit    (dec_hit),
    .per_sel    (per_sel),
    .per_stb    (per_stb),
    .per_addr   (per_addr),
    .per_wr     (per_wr),
    .per_wdata  (per_wdata),
    .bus_rdy    (bus_rdy),
    .in_access  (in_access)
  );

  apb_read_mux #(.NP(NP), .DW(DW)) u_rmux (
    .en     (in_access),
    .sel    (per_sel),
    .rd_all (per_rdata),
    .rd_out (bus_rdata)
  );

  assign bus_resp = RESP_OKAY;

  // R7: never more than one peripheral selected
  p_onehot_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_sel));

  // R8: the access cycle releases the stall
  p_access_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    per_stb |-> bus_rdy);

endmodule

// File: tb/ahb2apb_bridge_bench.sv
module ahb2apb_bridge_bench;
  import bridge_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NP = 4;

  typedef struct packed {
    logic        wr;
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  exp_sel;
  } vec_t;

  // stimulus and expected select (slot = addr[13:12], R7)
  localparam vec_t VECS [8] = '{
    '{1'b0, 2'b10, 32'h0000_0010, 32'h0000_0000, 4'b0001},
    '{1'b1, 2'b10, 32'h0000_1024, 32'h1111_2222, 4'b0010},
    '{1'b0, 2'b11, 32'h0000_2008, 32'h0000_0000, 4'b0100},
    '{1'b1, 2'b11, 32'h0000_3FFC, 32'hDEAD_BEEF, 4'b1000},
    '{1'b0, 2'b00, 32'h0000_1000, 32'h0000_0000, 4'b0000},
    '{1'b1, 2'b01, 32'h0000_2000, 32'h5555_AAAA, 4'b0000},
    '{1'b0, 2'b10, 32'hFFFF_F000, 32'h0000_0000, 4'b1000},
    '{1'b1, 2'b10, 32'h0000_0000, 32'h0000_0000, 4'b0001}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_sel = 1'b0;
  logic [AW-1:0]    bus_addr = '0;
  logic [1:0]       bus_kind = KIND_IDLE;
  logic             bus_wr = 1'b0;
  logic [DW-1:0]    bus_wdata = '0;
  logic             bus_rdy_in;
  logic             force_low = 1'b0;
  logic             bus_rdy;
  logic [1:0]       bus_resp;
  logic [DW-1:0]    bus_rdata;
  logic [NP-1:0]    per_sel;
  logic             per_stb;
  logic [AW-1:0]    per_addr;
  logic             per_wr;
  logic [DW-1:0]    per_wdata;
  logic [NP*DW-1:0] per_rdata;
  logic [7:0]       salt = 8'h00;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_rdy_in = bus_rdy & ~force_low;

  for (genvar g = 0; g < NP; g++) begin : g_prd
    assign per_rdata[g*DW +: DW] = 32'hC0DE_0000 | {16'h0, salt, 8'h0} | 32'(g);
  end

  ahb2apb_bridge u_ahb2apb_bridge (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_kind(bus_kind), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdy_in(bus_rdy_in), .bus_rdy(bus_rdy), .bus_resp(bus_resp),
    .bus_rdata(bus_rdata), .per_sel(per_sel), .per_stb(per_stb),
    .per_addr(per_addr), .per_wr(per_wr), .per_wdata(per_wdata),
    .per_rdata(per_rdata)
  );

  function automatic logic [31:0] exp_rd(input int idx);
    return 32'hC0DE_0000 | {16'h0, salt, 8'h0} | 32'(idx);
  endfunction

  function automatic int idx_of(input logic [3:0] oh);
    for (int i = 0; i < 4; i++) if (oh[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    bus_sel  = 1'b0;
    bus_kind = KIND_IDLE;
    bus_addr = 32'hEEEE_EEEE;
  endtask

  task automatic drive_beat(input logic wr, input logic [1:0] kind, input logic [31:0] addr);
    bus_sel  = 1'b1;
    bus_kind = kind;
    bus_wr   = wr;
    bus_addr = addr;
  endtask

  task automatic check_quiet(input string req);
    chk({req, " sel"}, 64'(per_sel), 64'h0);
    chk({req, " stb"}, 64'(per_stb), 64'h0);
    chk({req, " rdy"}, 64'(bus_rdy), 64'h1);
    chk({req, " resp"}, 64'(bus_resp), 64'(RESP_OKAY));
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    drive_beat(v.wr, v.kind, v.addr);
    bus_wdata = ~v.data;
    @(negedge clk);
    drive_idle();
    bus_wdata = v.data;
    if (!v.kind[1]) begin
      check_quiet("R2 no-start beat");
      @(negedge clk);
      check_quiet("R2 no-start beat later");
      return;
    end
    if (v.wr) begin
      chk("R4 data wait rdy", 64'(bus_rdy), 64'h0);
      chk("R4 data wait sel", 64'(per_sel), 64'h0);
      @(negedge clk);
      bus_wdata = 32'h0BAD_0BAD;
    end
    // setup
    chk("R7 setup sel", 64'(per_sel), 64'(v.exp_sel));
    chk("R3 setup stb", 64'(per_stb), 64'h0);
    chk("R3 setup rdy", 64'(bus_rdy), 64'h0);
    chk("R6 setup addr", 64'(per_addr), 64'(v.addr));
    chk("R6 setup wr", 64'(per_wr), 64'(v.wr));
    if (v.wr) chk("R4 setup wdata", 64'(per_wdata), 64'(v.data));
    @(negedge clk);
    // access
    chk("R3 access stb", 64'(per_stb), 64'h1);
    chk("R6 access sel", 64'(per_sel), 64'(v.exp_sel));
    chk("R6 access addr", 64'(per_addr), 64'(v.addr));
    chk("R8 access rdy", 64'(bus_rdy), 64'h1);
    chk("R8 access resp", 64'(bus_resp), 64'(RESP_OKAY));
    if (v.wr) chk("R4 access wdata", 64'(per_wdata), 64'(v.data));
    else      chk("R8 read data", 64'(bus_rdata), 64'(exp_rd(idx_of(v.exp_sel))));
    @(negedge clk);
    check_quiet("R3 back to idle");
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    drive_idle();
    repeat (3) @(negedge clk);
    check_quiet("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1 after reset");

    // table walk
    for (int k = 0; k < 8; k++) begin
      salt = 8'(k + 1);
      run_vec(VECS[k]);
    end

    // R9: read, then write taken in access, then read taken in access
    salt = 8'h55;
    @(negedge clk);
    drive_beat(1'b0, KIND_NONSEQ, 32'h0000_1000);
    @(negedge clk);
    drive_idle();
    chk("R3 b2b setup sel", 64'(per_sel), 64'h2);
    @(negedge clk);
    drive_beat(1'b1, KIND_NONSEQ, 32'h0000_3010);
    bus_wdata = 32'hFFFF_0000;
    chk("R8 b2b read data", 64'(bus_rdata), 64'(exp_rd(1)));
    chk("R8 b2b access rdy", 64'(bus_rdy), 64'h1);
    @(negedge clk);
    drive_idle();
    bus_wdata = 32'h0000_0077;
    chk("R9 write wait after access rdy", 64'(bus_rdy), 64'h0);
    chk("R9 write wait after access sel", 64'(per_sel), 64'h0);
    @(negedge clk);
    chk("R9 second setup sel", 64'(per_sel), 64'h8);
    chk("R9 second setup addr", 64'(per_addr), 64'h0000_3010);
    chk("R9 second setup wdata", 64'(per_wdata), 64'h0000_0077);
    @(negedge clk);
    drive_beat(1'b0, KIND_SEQ, 32'h0000_0004);
    chk("R9 write access stb", 64'(per_stb), 64'h1);
    @(negedge clk);
    drive_idle();
    chk("R9 read setup at once sel", 64'(per_sel), 64'h1);
    chk("R9 read setup at once stb", 64'(per_stb), 64'h0);
    chk("R9 read setup wr", 64'(per_wr), 64'h0);
    @(negedge clk);
    chk("R8 b2b second read", 64'(bus_rdata), 64'(exp_rd(0)));
    @(negedge clk);
    check_quiet("R9 idle after chain");

    // R10: bus-wide ready low blocks sampling
    @(negedge clk);
    force_low = 1'b1;
    drive_beat(1'b0, KIND_NONSEQ, 32'h0000_2000);
    @(negedge clk);
    force_low = 1'b0;
    drive_idle();
    check_quiet("R10 ready low no start");
    @(negedge clk);
    check_quiet("R10 ready low later");

    // R2: deselected nonsequential beat
    @(negedge clk);
    drive_beat(1'b1, KIND_NONSEQ, 32'h0000_1000);
    bus_sel = 1'b0;
    @(negedge clk);
    drive_idle();
    check_quiet("R2 deselected");

    // R1: reset in the middle of a transfer
    @(negedge clk);
    drive_beat(1'b0, KIND_NONSEQ, 32'h0000_2000);
    @(negedge clk);
    drive_idle();
    chk("R3 pre-reset setup", 64'(per_sel), 64'h4);
    rst_n = 1'b0;
    #1;
    check_quiet("R1 mid-transfer reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_quiet("R1 after mid reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule